// File: doc/BRIEF.md
# Backplane Slave Primary-Address Decoder

This block sits in a slave module on a parallel backplane bus. It watches the primary address cycle and decides whether the module takes part in the data cycles that follow. Three addressing kinds are accepted. Geographic addressing matches the slot number. Logical addressing matches a programmed 16-bit logical address. Broadcast addressing uses a case code in the low address byte. Register space and data space are decoded the same way, and the chosen space is reported while the module is selected.

Some broadcast codes do not select the module. Instead they arm a T-pin response that is driven during the next read cycle, either always or depending on live data-status inputs. A broadcast takes several clock cycles to decode. Once that time passes the handshake budget, the block raises a WAIT request until the decode completes. The selection, or the armed response, is held until the address strobe is released.

Top module: `bcast_addr_decoder`

## Requirements
- R1: With the strobe sampled high in idle, `bcast_i`=0 and `geo_i`=1, `sel_o` rises after that single clock edge exactly when `addr_i[4:0]` equals `slot_i`.
- R2: With `bcast_i`=0 and `geo_i`=0, `sel_o` rises after that single clock edge exactly when `addr_i[31:16]` equals `la_cfg_i`.
- R3: `data_space_o` is 1 only while `sel_o` is 1 and the space select captured with the address was data space (1). Selection does not depend on the space.
- R4: Broadcast code `addr_i[7:0]`=0x01 selects the module.
- R5: Broadcast code 0x05 selects the module only when the class number `addr_i[15:8]` is below 4 and `class_en_i` has that bit set.
- R6: After broadcast code 0x09 or 0x19, `tpin_o` equals `rd_i & has_data_i`.
- R7: After broadcast code 0x0D, `tpin_o` equals `rd_i`.
- R8: After broadcast code 0xCD, `tpin_o` equals `rd_i & next_unsupp_i`.
- R9: Any other broadcast code leaves `sel_o` and `tpin_o` at 0. A broadcast that selects the module arms no T-pin response, and `tpin_o` is never 1 without `rd_i`.
- R10: A broadcast result appears BCAST_LAT (4) clock edges after capture. Earlier results stay at 0. Counting the capture edge as the first, `wait_o` is 1 after edges HS_CYC (2) through BCAST_LAT-1 and 0 otherwise.
- R11: While the strobe stays high, the result is held and address changes are ignored. The clock edge after the strobe is released clears `sel_o`, `data_space_o` and any armed T-pin response.
- R12: While reset is active, and just after it is released, `sel_o`, `data_space_o`, `tpin_o` and `wait_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| as_i | input | 1 | Address strobe, high for the whole transaction |
| addr_i | input | 32 | Primary address |
| data_space_i | input | 1 | Space select: 1 data space, 0 register space |
| bcast_i | input | 1 | Broadcast address cycle |
| geo_i | input | 1 | Geographic (1) or logical (0) for non-broadcast cycles |
| slot_i | input | 5 | Slot number of this module |
| la_cfg_i | input | 16 | Programmed logical address |
| class_en_i | input | 4 | Enable per broadcast class |
| rd_i | input | 1 | Read data cycle in progress |
| has_data_i | input | 1 | Module holds buffered data |
| next_unsupp_i | input | 1 | Next buffer holds unsuppressed data |
| sel_o | output | 1 | Module selected for the data cycles |
| data_space_o | output | 1 | Selected in data space |
| tpin_o | output | 1 | T-pin response |
| wait_o | output | 1 | WAIT request during slow broadcast decode |

## Verification
Two things can meet in one cycle: the read that samples the armed T-pin response, and a change of the data-status inputs. The bench changes `has_data_i` and `next_unsupp_i` at random during the read for every T-pin code. It judges `tpin_o` against the live values, not against values captured at decode time. A second case is a strobe held high after a broadcast while the address lines change. The bench changes them at random and checks that the held result does not move. It also checks that the WAIT window ends on the same edge that the result appears.

// File: rtl/bcast_dec_pkg.sv
package bcast_dec_pkg;

    typedef enum logic [1:0] {
        TM_NONE   = 2'd0,
        TM_ALWAYS = 2'd1,
        TM_DATA   = 2'd2,
        TM_NEXT   = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_HOLD   = 2'd2
    } state_e;

    typedef struct packed {
        logic   sel;
        tmode_e tmode;
    } verdict_t;

    localparam logic [7:0] CODE_ALL      = 8'h01;
    localparam logic [7:0] CODE_CLASS    = 8'h05;
    localparam logic [7:0] CODE_SCAN     = 8'h09;
    localparam logic [7:0] CODE_SCAN_ALT = 8'h19;
    localparam logic [7:0] CODE_TALL     = 8'h0D;
    localparam logic [7:0] CODE_NEXTBUF  = 8'hCD;

endpackage

// File: rtl/bcast_case_decode.sv
module bcast_case_decode
    import bcast_dec_pkg::*;
#(
    parameter int CLASS_W   = 8,
    parameter int NUM_CLASS = 4
) (
    input  logic [7:0]           code_i,
    input  logic [CLASS_W-1:0]   class_num_i,
    input  logic [NUM_CLASS-1:0] class_en_i,
    output verdict_t             res_o
);

    logic [NUM_CLASS-1:0] class_hit;
    logic                 class_ok;

    // one comparator per supported class
    generate
        for (genvar g = 0; g < NUM_CLASS; g++) begin : g_class
            assign class_hit[g] = (class_num_i == CLASS_W'(g)) && class_en_i[g];
        end
    endgenerate

    assign class_ok = |class_hit;

    always_comb begin
        res_o = '{sel: 1'b0, tmode: TM_NONE};
        unique case (code_i)
            CODE_ALL:      res_o.sel   = 1'b1;
            CODE_CLASS:    res_o.sel   = class_ok;
            CODE_SCAN,
            CODE_SCAN_ALT: res_o.tmode = TM_DATA;
            CODE_TALL:     res_o.tmode = TM_ALWAYS;
            CODE_NEXTBUF:  res_o.tmode = TM_NEXT;
            default:       res_o       = '{sel: 1'b0, tmode: TM_NONE};
        endcase
    end

endmodule

// File: rtl/direct_match.sv
module direct_match #(
    parameter int SLOT_W = 5,
    parameter int LA_W   = 16
) (
    input  logic [31:0]       addr_i,
    input  logic              geo_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [LA_W-1:0]   la_cfg_i,
    output logic              hit_o
);

    localparam int LA_LSB = 32 - LA_W;

    logic geo_hit;
    logic log_hit;

    assign geo_hit = (addr_i[SLOT_W-1:0] == slot_i);
    assign log_hit = (addr_i[31:LA_LSB] == la_cfg_i);
    assign hit_o   = geo_i ? geo_hit : log_hit;

endmodule

// File: rtl/tpin_drive.sv
module tpin_drive
    import bcast_dec_pkg::*;
(
    input  tmode_e tmode_i,
    input  logic   rd_i,
    input  logic   has_data_i,
    input  logic   next_unsupp_i,
    output logic   tpin_o
);

    always_comb begin
        unique case (tmode_i)
            TM_ALWAYS: tpin_o = rd_i;
            TM_DATA:   tpin_o = rd_i && has_data_i;
            TM_NEXT:   tpin_o = rd_i && next_unsupp_i;
            default:   tpin_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcast_addr_decoder.sv
module bcast_addr_decoder
    import bcast_dec_pkg::*;
#(
    parameter int SLOT_W    = 5,
    parameter int LA_W      = 16,
    parameter int NUM_CLASS = 4,
    parameter int BCAST_LAT = 4,
    parameter int HS_CYC    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 as_i,
    input  logic [31:0]          addr_i,
    input  logic                 data_space_i,
    input  logic                 bcast_i,
    input  logic                 geo_i,
    input  logic [SLOT_W-1:0]    slot_i,
    input  logic [LA_W-1:0]      la_cfg_i,
    input  logic [NUM_CLASS-1:0] class_en_i,
    input  logic                 rd_i,
    input  logic                 has_data_i,
    input  logic                 next_unsupp_i,
    output logic                 sel_o,
    output logic                 data_space_o,
    output logic                 tpin_o,
    output logic                 wait_o
);

    localparam int CNT_W   = $clog2(BCAST_LAT + 1);
    localparam int CLASS_W = 8;

    typedef struct packed {
        state_e      state;
        logic [CNT_W-1:0] cnt;
        logic [15:0] code;
        logic        space;
        logic        sel;
        tmode_e      tmode;
        logic        wait_req;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state: ST_IDLE, cnt: '0, code: '0, space: 1'b0,
        sel: 1'b0, tmode: TM_NONE, wait_req: 1'b0
    };

    regs_t    r_q, r_d;
    verdict_t bres;
    logic     direct_hit;

    direct_match #(.SLOT_W(SLOT_W), .LA_W(LA_W)) u_direct (
        .addr_i   (addr_i),
        .geo_i    (geo_i),
        .slot_i   (slot_i),
        .la_cfg_i (la_cfg_i),
        .hit_o    (direct_hit)
    );

    bcast_case_decode #(.CLASS_W(CLASS_W), .NUM_CLASS(NUM_CLASS)) u_case (
        .code_i      (r_q.code[7:0]),
        .class_num_i (r_q.code[15:8]),
        .class_en_i  (class_en_i),
        .res_o       (bres)
    );

    tpin_drive u_tpin (
        .tmode_i       (r_q.tmode),
        .rd_i          (rd_i),
        .has_data_i    (has_data_i),
        .next_unsupp_i (next_unsupp_i),
        .tpin_o        (tpin_o)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (as_i) begin
                    r_d.code  = addr_i[15:0];
                    r_d.space = data_space_i;
                    if (bcast_i) begin
                        r_d.state    = ST_DECODE;
                        r_d.cnt      = CNT_W'(1);
                        r_d.wait_req = (HS_CYC <= 1);
                    end else begin
                        r_d.state = ST_HOLD;
                        r_d.sel   = direct_hit;
                        r_d.tmode = TM_NONE;
                    end
                end
            end
            ST_DECODE: begin
                if (!as_i) begin
                    r_d = REGS_RST;
                end else if (r_q.cnt == CNT_W'(BCAST_LAT - 1)) begin
                    r_d.state    = ST_HOLD;
                    r_d.sel      = bres.sel;
                    r_d.tmode    = bres.tmode;
                    r_d.wait_req = 1'b0;
                end else begin
                    r_d.cnt      = r_q.cnt + CNT_W'(1);
                    r_d.wait_req = (r_d.cnt >= CNT_W'(HS_CYC));
                end
            end
            ST_HOLD: begin
                if (!as_i) begin
                    r_d = REGS_RST;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_o        = r_q.sel;
    assign data_space_o = r_q.sel && r_q.space;
    assign wait_o       = r_q.wait_req;

endmodule

// File: rtl/bcast_addr_decoder_chk.sv
module bcast_addr_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic as_i,
    input logic rd_i,
    input logic sel_o,
    input logic data_space_o,
    input logic tpin_o,
    input logic wait_o
);

    // R9: no T-pin response outside a read
    p_tpin_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tpin_o |-> rd_i)
        else $error("tpin without read");

    // R9: selection and T-pin response exclude each other
    p_sel_excl_tpin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> !tpin_o)
        else $error("sel and tpin together");

    // R11: release clears everything on the next edge
    p_release_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !as_i |=> (!sel_o && !data_space_o && !wait_o))
        else $error("state kept after strobe release");

    // R11: selection held while strobe stays high
    p_sel_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && as_i) |=> sel_o)
        else $error("selection dropped under strobe");

    // R10: WAIT only during decode, never with a result
    p_wait_no_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> (!sel_o && !tpin_o))
        else $error("wait with result");

    // R3: data space only when selected
    p_space_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_space_o |-> sel_o)
        else $error("space without selection");

endmodule

bind bcast_addr_decoder bcast_addr_decoder_chk u_chk (.*);

// File: tb/bcast_addr_decoder_tb_top.sv
`timescale 1ns/1ps
module bcast_addr_decoder_tb_top;

    localparam int LAT = 4;
    localparam int HS  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        data_space_i = 1'b0;
    logic        bcast_i = 1'b0;
    logic        geo_i = 1'b0;
    logic [4:0]  slot_i = 5'd9;
    logic [15:0] la_cfg_i = 16'hA5C3;
    logic [3:0]  class_en_i = 4'b0101;
    logic        rd_i = 1'b0;
    logic        has_data_i = 1'b0;
    logic        next_unsupp_i = 1'b0;
    logic        sel_o, data_space_o, tpin_o, wait_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bcast_addr_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .as_i(as_i), .addr_i(addr_i),
        .data_space_i(data_space_i), .bcast_i(bcast_i), .geo_i(geo_i),
        .slot_i(slot_i), .la_cfg_i(la_cfg_i), .class_en_i(class_en_i),
        .rd_i(rd_i), .has_data_i(has_data_i), .next_unsupp_i(next_unsupp_i),
        .sel_o(sel_o), .data_space_o(data_space_o), .tpin_o(tpin_o),
        .wait_o(wait_o)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    function automatic bit exp_sel(input logic [31:0] a, input bit bc, input bit geo);
        if (!bc) return geo ? (a[4:0] == slot_i) : (a[31:16] == la_cfg_i);
        if (a[7:0] == 8'h01) return 1'b1;
        if (a[7:0] == 8'h05) return (a[15:8] < 8'd4) && class_en_i[a[9:8]];
        return 1'b0;
    endfunction

    // 0 none, 1 always, 2 data present, 3 next buffer
    function automatic int exp_kind(input logic [31:0] a, input bit bc);
        if (!bc) return 0;
        case (a[7:0])
            8'h09, 8'h19: return 2;
            8'h0D:        return 1;
            8'hCD:        return 3;
            default:      return 0;
        endcase
    endfunction

    function automatic bit exp_t(input int kind, input bit rd, input bit hd, input bit nu);
        case (kind)
            1: return rd;
            2: return rd && hd;
            3: return rd && nu;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [31:0] a, input bit bc, input bit geo);
        if (!bc) return geo ? "R1" : "R2";
        case (a[7:0])
            8'h01: return "R4";
            8'h05: return "R5";
            8'h09, 8'h19: return "R6";
            8'h0D: return "R7";
            8'hCD: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic access(input logic [31:0] a, input bit sp, input bit bc, input bit geo);
        bit    es;
        int    kind;
        string rq;
        es   = exp_sel(a, bc, geo);
        kind = exp_kind(a, bc);
        rq   = req_of(a, bc, geo);
        @(negedge clk);
        addr_i = a; data_space_i = sp; bcast_i = bc; geo_i = geo;
        as_i = 1'b1; rd_i = 1'b0;
        if (bc) begin
            for (int k = 1; k < LAT; k++) begin
                @(negedge clk);
                chk(wait_o == (k >= HS), "R10 wait", wait_o, (k >= HS));
                chk(sel_o == 1'b0, "R10 early sel", sel_o, 0);
            end
        end
        @(negedge clk);
        chk(sel_o == es, rq, sel_o, es);
        chk(wait_o == 1'b0, "R10 wait end", wait_o, 0);
        chk(data_space_o == (es && sp), "R3", data_space_o, (es && sp));
        // address lines move while held
        addr_i = $urandom; bcast_i = $urandom; geo_i = $urandom;
        chk(tpin_o == 1'b0, "R9 no read", tpin_o, 0);
        rd_i = 1'b1; has_data_i = $urandom; next_unsupp_i = $urandom;
        #1;
        chk(tpin_o == exp_t(kind, 1'b1, has_data_i, next_unsupp_i), rq, tpin_o,
            exp_t(kind, 1'b1, has_data_i, next_unsupp_i));
        has_data_i = ~has_data_i; next_unsupp_i = ~next_unsupp_i;
        #1;
        chk(tpin_o == exp_t(kind, 1'b1, has_data_i, next_unsupp_i), {rq, " live"}, tpin_o,
            exp_t(kind, 1'b1, has_data_i, next_unsupp_i));
        @(negedge clk);
        chk(sel_o == es, "R11 held", sel_o, es);
        rd_i = 1'b0; as_i = 1'b0;
        @(negedge clk);
        chk(sel_o == 1'b0 && data_space_o == 1'b0, "R11 release", sel_o, 0);
        rd_i = 1'b1; has_data_i = 1'b1; next_unsupp_i = 1'b1;
        #1;
        chk(tpin_o == 1'b0, "R11 disarm", tpin_o, 0);
        rd_i = 1'b0;
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] codes [8];
        void'($urandom(32'd1234));
        codes = '{8'h01, 8'h05, 8'h09, 8'h19, 8'h0D, 8'hCD, 8'hBD, 8'h11};
        repeat (3) @(negedge clk);
        chk(!sel_o && !data_space_o && !tpin_o && !wait_o, "R12 in reset", sel_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sel_o && !data_space_o && !tpin_o && !wait_o, "R12 after reset", sel_o, 0);

        // directed corners
        access({16'h0, 11'h0, 5'd9}, 1'b1, 1'b0, 1'b1);   // R1 hit, data space
        access({16'h0, 11'h0, 5'd8}, 1'b0, 1'b0, 1'b1);   // R1 miss
        access({16'hA5C3, 16'h0}, 1'b0, 1'b0, 1'b0);      // R2 hit, register space
        access({16'hA5C2, 16'h0}, 1'b1, 1'b0, 1'b0);      // R2 miss
        access(32'h0000_0001, 1'b1, 1'b1, 1'b0);          // R4
        access(32'h0000_0205, 1'b0, 1'b1, 1'b0);          // R5 class 2 enabled
        access(32'h0000_0105, 1'b0, 1'b1, 1'b0);          // R5 class 1 disabled
        access(32'h0000_0405, 1'b0, 1'b1, 1'b0);          // R5 class out of range
        access(32'h0000_0009, 1'b1, 1'b1, 1'b0);          // R6
        access(32'h0000_0019, 1'b0, 1'b1, 1'b0);          // R6 variant
        access(32'h0000_000D, 1'b0, 1'b1, 1'b0);          // R7
        access(32'h0000_00CD, 1'b0, 1'b1, 1'b0);          // R8
        access(32'h0000_00BD, 1'b0, 1'b1, 1'b0);          // R9

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            bit bc, geo, sp;
            bc  = $urandom;
            geo = $urandom;
            sp  = $urandom;
            class_en_i = $urandom;
            a = $urandom;
            if (bc) begin
                a[7:0]  = ($urandom_range(0, 9) < 9) ? codes[$urandom_range(0, 7)] : 8'($urandom);
                a[15:8] = 8'($urandom_range(0, 5));
            end else if ($urandom_range(0, 1) == 0) begin
                if (geo) a[4:0] = slot_i; else a[31:16] = la_cfg_i;
            end
            access(a, sp, bc, geo);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule